// File: doc/BRIEF.md
# Pulse-Swallow Feedback and Reference Divider with Guarded Reload

This block holds the digital counters of a frequency synthesiser's two dividers. The feedback side runs on the output clock of an external dual-modulus prescaler that divides by P or P+1. It drives a modulus-select line to that prescaler, so the whole loop divides by M·P + A. It emits a one-cycle pulse at the start of each feedback cycle. The reference side divides its own clock by a 13-bit ratio R and emits a one-cycle pulse per reference cycle.

A control block writes new ratios into buffer words and raises a pending flag. Each counter copies the buffer only at a point in its count where the copy cannot corrupt a reload in progress. It answers with a single-cycle acknowledge and starts using the new ratio at its next reload. A second feedback update kind changes only the swallow count A at the end of the running feedback cycle, for fast hops to a neighbouring channel. Ratios that cannot be counted are acknowledged and discarded. A two-bit power-down code can hold both divider pulse outputs low while the counters keep running.

Top module: `swallow_div`

## Requirements
- R1: `fb_pulse` is high for exactly one `fb_clk` cycle at the start of each feedback cycle, and the spacing between pulses equals the active M.
- R2: `modulus_hi` is high for exactly the first A cycles of each feedback cycle and low for the remaining M − A cycles, so the loop divides by M·P + A.
- R3: A full feedback update (`fb_pend`=1, `fb_a_only`=0) is accepted only in a cycle where the remaining M count is greater than 3. The new M and A take effect from the next feedback cycle. The smallest valid M is 4, and a full update is still accepted while running at M = 4.
- R4: An A-only update (`fb_pend`=1, `fb_a_only`=1) is accepted only in the last cycle of the M count. The new A applies from the feedback cycle that starts next. M stays unchanged and `fb_m_word` is ignored.
- R5: A reference update is accepted only in a cycle where the remaining R count is greater than 1. The new R takes effect from the next reference cycle.
- R6: `ref_pulse` is high for exactly one `ref_clk` cycle per reference cycle, and the spacing between pulses equals the 13-bit R, for any R from 2 to 8191.
- R7: While `pd_sel` = 2'b00, `fb_pulse` and `ref_pulse` stay low, one clock after the code is applied. The other three codes enable both outputs. The counters and `modulus_hi` keep running in every code.
- R8: Some written ratios are invalid and are discarded: a feedback word with M < 4, a feedback word with M ≤ A (A taken after the masking of R9), and a reference word with R < 2. The update is still acknowledged and the previous ratio stays in force.
- R9: While `prescaler_narrow` = 1, bit 3 of `fb_a_word` is ignored at transfer, so A is limited to 0..7.
- R10: Every accepted or discarded update gives exactly one single-cycle pulse on `fb_ack` or `ref_ack`, in the clock cycle after the transfer edge. The pending flag must be held until that pulse is seen.
- R11: After reset the ratios are M = 8, A = 0 and R = 6 (parameter defaults), and `fb_pulse`, `ref_pulse`, `modulus_hi`, `fb_ack` and `ref_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fb_clk | input | 1 | Prescaler output clock; one cycle per prescaler output period |
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both counter domains |
| pd_sel | input | 2 | Power-down code; 2'b00 holds both divider pulses low |
| prescaler_narrow | input | 1 | Prescaler in the 8/9 modulus pair; A is limited to 3 bits |
| fb_m_word | input | 10 | Buffered M ratio |
| fb_a_word | input | 4 | Buffered A (swallow) count |
| fb_pend | input | 1 | Feedback buffer holds an update |
| fb_a_only | input | 1 | Pending feedback update changes A only |
| fb_ack | output | 1 | One-cycle pulse: feedback buffer consumed |
| modulus_hi | output | 1 | Prescaler modulus select: 1 = divide by P+1 |
| fb_pulse | output | 1 | Feedback divider output pulse |
| ref_r_word | input | 13 | Buffered R ratio |
| ref_pend | input | 1 | Reference buffer holds an update |
| ref_ack | output | 1 | One-cycle pulse: reference buffer consumed |
| ref_pulse | output | 1 | Reference divider output pulse |

## Verification
The bench builds the block with its defaults: 10-bit M, 4-bit A, 13-bit R and reset ratios 8/0/6. These make the full 13-bit reference range (R = 8191) and the smallest legal M of 4 quick to reach. Both clocks run from one source, so feedback and reference updates interleave freely. Small reset ratios leave the reset state visible within a few pulses. Running at M = 4 gives only one safe cycle per feedback period, which stresses the transfer window. R = 2 does the same on the reference side.

// File: rtl/swallow_pkg.sv
package swallow_pkg;

  // Remaining counts above which a buffer copy is safe
  localparam int unsigned FB_SAFE_REM  = 3;
  localparam int unsigned REF_SAFE_REM = 1;
  localparam int unsigned MIN_M        = 4;
  localparam int unsigned MIN_R        = 2;
  localparam int unsigned NARROW_A_MAX = 7;

  typedef enum logic [1:0] {
    PD_ALL_OFF   = 2'b00,
    PD_ALL_ON    = 2'b01,
    PD_PUMP_OFF  = 2'b10,
    PD_PUMP_LOCK = 2'b11
  } pd_mode_e;

  // Swallow count after the narrow-prescaler mask
  function automatic int unsigned swallow_eff(int unsigned a_raw, logic narrow);
    return narrow ? (a_raw & NARROW_A_MAX) : a_raw;
  endfunction

  // A feedback pair is countable when M is long enough and exceeds A
  function automatic logic fb_pair_ok(int unsigned m, int unsigned a);
    return (m >= MIN_M) && (m > a);
  endfunction

  function automatic logic ref_ratio_ok(int unsigned r);
    return r >= MIN_R;
  endfunction

  function automatic logic outputs_on(pd_mode_e pd);
    return pd != PD_ALL_OFF;
  endfunction

endpackage

// File: rtl/swallow_fb_ctr.sv
module swallow_fb_ctr
  import swallow_pkg::*;
#(
  parameter int unsigned M_W     = 10,
  parameter int unsigned A_W     = 4,
  parameter int unsigned M_RESET = 8,
  parameter int unsigned A_RESET = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] m_word,
  input  logic [A_W-1:0] a_word,
  input  logic           narrow_a,
  input  logic           pend,
  input  logic           a_only,
  output logic [M_W-1:0] m_rem,
  output logic           tc,
  output logic           mod_hi,
  output logic           ack
);

  logic [M_W-1:0] m_cnt, m_act;
  logic [A_W-1:0] a_cnt, a_act;
  logic [A_W-1:0] a_new;
  logic           ack_q;
  logic           word_ok, aonly_ok;
  logic           ld_full, ld_aonly;

  assign a_new    = A_W'(swallow_eff(32'(a_word), narrow_a));
  assign word_ok  = fb_pair_ok(32'(m_word), 32'(a_new));
  assign aonly_ok = fb_pair_ok(32'(m_act), 32'(a_new));

  assign tc       = (m_cnt == M_W'(1));
  assign ld_full  = pend & ~a_only & ~ack_q & (32'(m_cnt) > FB_SAFE_REM);
  assign ld_aonly = pend & a_only & ~ack_q & tc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= M_W'(M_RESET);
      m_act <= M_W'(M_RESET);
      a_cnt <= A_W'(A_RESET);
      a_act <= A_W'(A_RESET);
      ack_q <= 1'b0;
    end else begin
      ack_q <= ld_full | ld_aonly;
      if (ld_full && word_ok) begin
        m_act <= m_word;
        a_act <= a_new;
      end
      if (tc) begin
        m_cnt <= m_act;
        if (ld_aonly && aonly_ok) begin
          a_cnt <= a_new;
          a_act <= a_new;
        end else begin
          a_cnt <= a_act;
        end
      end else begin
        m_cnt <= m_cnt - M_W'(1);
        if (a_cnt != '0) a_cnt <= a_cnt - A_W'(1);
      end
    end
  end

  assign m_rem  = m_cnt;
  assign mod_hi = (a_cnt != '0);
  assign ack    = ack_q;

endmodule

// File: rtl/swallow_ref_ctr.sv
module swallow_ref_ctr
  import swallow_pkg::*;
#(
  parameter int unsigned R_W     = 13,
  parameter int unsigned R_RESET = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [R_W-1:0] r_word,
  input  logic           pend,
  output logic [R_W-1:0] r_rem,
  output logic           tc,
  output logic           ack
);

  logic [R_W-1:0] r_cnt, r_act;
  logic           ack_q;
  logic           ld;

  assign tc = (r_cnt == R_W'(1));
  assign ld = pend & ~ack_q & (32'(r_cnt) > REF_SAFE_REM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_cnt <= R_W'(R_RESET);
      r_act <= R_W'(R_RESET);
      ack_q <= 1'b0;
    end else begin
      ack_q <= ld;
      if (ld && ref_ratio_ok(32'(r_word))) r_act <= r_word;
      if (tc) r_cnt <= r_act;
      else    r_cnt <= r_cnt - R_W'(1);
    end
  end

  assign r_rem = r_cnt;
  assign ack   = ack_q;

endmodule

// File: rtl/swallow_pulse_gate.sv
module swallow_pulse_gate
  import swallow_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pulse_in,
  input  logic [1:0] pd_sel,
  output logic       pulse_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_out <= 1'b0;
    else        pulse_out <= pulse_in & outputs_on(pd_mode_e'(pd_sel));
  end

endmodule

// File: rtl/swallow_div.sv
module swallow_div #(
  parameter int unsigned M_W     = 10,
  parameter int unsigned A_W     = 4,
  parameter int unsigned R_W     = 13,
  parameter int unsigned M_RESET = 8,
  parameter int unsigned A_RESET = 0,
  parameter int unsigned R_RESET = 6
) (
  input  logic           fb_clk,
  input  logic           ref_clk,
  input  logic           rst_n,
  input  logic [1:0]     pd_sel,
  input  logic           prescaler_narrow,
  input  logic [M_W-1:0] fb_m_word,
  input  logic [A_W-1:0] fb_a_word,
  input  logic           fb_pend,
  input  logic           fb_a_only,
  output logic           fb_ack,
  output logic           modulus_hi,
  output logic           fb_pulse,
  input  logic [R_W-1:0] ref_r_word,
  input  logic           ref_pend,
  output logic           ref_ack,
  output logic           ref_pulse
);

  // Internal events brought out for the checker
  logic [M_W-1:0] m_rem;
  logic [R_W-1:0] r_rem;
  logic           fb_tc;
  logic           ref_tc;

  swallow_fb_ctr #(
    .M_W(M_W), .A_W(A_W), .M_RESET(M_RESET), .A_RESET(A_RESET)
  ) fb_ctr_i (
    .clk     (fb_clk),
    .rst_n   (rst_n),
    .m_word  (fb_m_word),
    .a_word  (fb_a_word),
    .narrow_a(prescaler_narrow),
    .pend    (fb_pend),
    .a_only  (fb_a_only),
    .m_rem   (m_rem),
    .tc      (fb_tc),
    .mod_hi  (modulus_hi),
    .ack     (fb_ack)
  );

  swallow_ref_ctr #(
    .R_W(R_W), .R_RESET(R_RESET)
  ) ref_ctr_i (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .r_word(ref_r_word),
    .pend  (ref_pend),
    .r_rem (r_rem),
    .tc    (ref_tc),
    .ack   (ref_ack)
  );

  swallow_pulse_gate fb_gate_i (
    .clk      (fb_clk),
    .rst_n    (rst_n),
    .pulse_in (fb_tc),
    .pd_sel   (pd_sel),
    .pulse_out(fb_pulse)
  );

  swallow_pulse_gate ref_gate_i (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .pulse_in (ref_tc),
    .pd_sel   (pd_sel),
    .pulse_out(ref_pulse)
  );

endmodule

// File: rtl/swallow_div_chk.sv
module swallow_div_chk #(
  parameter int unsigned M_W = 10,
  parameter int unsigned R_W = 13
) (
  input logic           fb_clk,
  input logic           ref_clk,
  input logic           rst_n,
  input logic [1:0]     pd_sel,
  input logic           fb_a_only,
  input logic [M_W-1:0] m_rem,
  input logic [R_W-1:0] r_rem,
  input logic           fb_tc,
  input logic           modulus_hi,
  input logic           fb_pulse,
  input logic           fb_ack,
  input logic           ref_pulse,
  input logic           ref_ack
);

  // R1: feedback pulse lasts one cycle
  a_r1_fb_pulse_single: assert property (@(posedge fb_clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  // R2: modulus select only rises right after a reload
  a_r2_mod_rise_at_start: assert property (@(posedge fb_clk) disable iff (!rst_n)
    $rose(modulus_hi) |-> $past(fb_tc));

  // R2: swallow count is exhausted by the end of the M count
  a_r2_mod_low_at_end: assert property (@(posedge fb_clk) disable iff (!rst_n)
    fb_tc |-> !modulus_hi);

  // R3: full update copied only with more than 3 counts left
  a_r3_full_safe: assert property (@(posedge fb_clk) disable iff (!rst_n)
    (fb_ack && !$past(fb_a_only)) |-> ($past(m_rem) > M_W'(3)));

  // R4: A-only update copied only at the end of the M count
  a_r4_aonly_at_end: assert property (@(posedge fb_clk) disable iff (!rst_n)
    (fb_ack && $past(fb_a_only)) |-> $past(fb_tc));

  // R5: reference update copied only with more than 1 count left
  a_r5_ref_safe: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_ack |-> ($past(r_rem) > R_W'(1)));

  // R6: reference pulse lasts one cycle
  a_r6_ref_pulse_single: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);

  // R7: power-down code holds both outputs low
  a_r7_fb_off: assert property (@(posedge fb_clk) disable iff (!rst_n)
    ($past(pd_sel) == 2'b00) |-> !fb_pulse);

  a_r7_ref_off: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ($past(pd_sel) == 2'b00) |-> !ref_pulse);

  // R10: acknowledges are single-cycle
  a_r10_fb_ack_single: assert property (@(posedge fb_clk) disable iff (!rst_n)
    fb_ack |=> !fb_ack);

  a_r10_ref_ack_single: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_ack |=> !ref_ack);

endmodule

bind swallow_div swallow_div_chk #(.M_W(M_W), .R_W(R_W)) chk_i (
  .fb_clk    (fb_clk),
  .ref_clk   (ref_clk),
  .rst_n     (rst_n),
  .pd_sel    (pd_sel),
  .fb_a_only (fb_a_only),
  .m_rem     (m_rem),
  .r_rem     (r_rem),
  .fb_tc     (fb_tc),
  .modulus_hi(modulus_hi),
  .fb_pulse  (fb_pulse),
  .fb_ack    (fb_ack),
  .ref_pulse (ref_pulse),
  .ref_ack   (ref_ack)
);

// File: tb/swallow_div_tb_top.sv
module swallow_div_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pd_sel = 2'b01;
  logic        prescaler_narrow = 1'b0;
  logic [9:0]  fb_m_word = '0;
  logic [3:0]  fb_a_word = '0;
  logic        fb_pend = 1'b0;
  logic        fb_a_only = 1'b0;
  logic        fb_ack, modulus_hi, fb_pulse;
  logic [12:0] ref_r_word = '0;
  logic        ref_pend = 1'b0;
  logic        ref_ack, ref_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  swallow_div dut_i (
    .fb_clk(clk), .ref_clk(clk), .rst_n(rst_n), .pd_sel(pd_sel),
    .prescaler_narrow(prescaler_narrow),
    .fb_m_word(fb_m_word), .fb_a_word(fb_a_word), .fb_pend(fb_pend),
    .fb_a_only(fb_a_only), .fb_ack(fb_ack), .modulus_hi(modulus_hi),
    .fb_pulse(fb_pulse), .ref_r_word(ref_r_word), .ref_pend(ref_pend),
    .ref_ack(ref_ack), .ref_pulse(ref_pulse)
  );

  typedef struct {
    int    period;
    int    hi;
    string tag;
  } fb_item_t;

  fb_item_t fb_q[$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: measures each feedback cycle between pulses
  int  mon_per = 0;
  int  mon_hi  = 0;
  bit  mon_run = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (fb_pulse) begin
        if (mon_run && fb_q.size() > 0) begin : pop_blk
          fb_item_t e;
          e = fb_q.pop_front();
          check(mon_per == e.period, e.tag, "feedback period", mon_per, e.period);
          check(mon_hi == e.hi, e.tag, "high-modulus cycles", mon_hi, e.hi);
        end
        mon_run = 1'b1;
        mon_per = 1;
        mon_hi  = modulus_hi ? 1 : 0;
      end else begin
        mon_per++;
        mon_hi += modulus_hi ? 1 : 0;
      end
    end
  end

  task automatic wait_fb_pulses(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      while (!fb_pulse) @(negedge clk);
    end
  endtask

  // Driver: write a feedback buffer and wait for its acknowledge (R10)
  task automatic fb_write(int m, int a, bit aonly, bit narrow);
    @(negedge clk);
    fb_m_word = 10'(m);
    fb_a_word = 4'(a);
    fb_a_only = aonly;
    prescaler_narrow = narrow;
    fb_pend = 1'b1;
    @(negedge clk);
    while (!fb_ack) @(negedge clk);
    check(fb_ack, "R10", "feedback ack seen", int'(fb_ack), 1);
    fb_pend = 1'b0;
    fb_a_only = 1'b0;
    @(negedge clk);
    check(!fb_ack, "R10", "feedback ack one cycle", int'(fb_ack), 0);
  endtask

  // Driver: push expected feedback cycles once the new ratio runs
  task automatic fb_expect(int period, int hi, int n, string tag);
    wait_fb_pulses(2);
    for (int i = 0; i < n; i++) fb_q.push_back('{period, hi, tag});
    while (fb_q.size() > 0) @(negedge clk);
  endtask

  task automatic ref_write(int r);
    @(negedge clk);
    ref_r_word = 13'(r);
    ref_pend = 1'b1;
    @(negedge clk);
    while (!ref_ack) @(negedge clk);
    check(ref_ack, "R10", "reference ack seen", int'(ref_ack), 1);
    ref_pend = 1'b0;
    @(negedge clk);
    check(!ref_ack, "R10", "reference ack one cycle", int'(ref_ack), 0);
  endtask

  task automatic ref_expect(int r, int n, string tag);
    @(negedge clk);
    while (!ref_pulse) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      int cnt = 0;
      do begin
        @(negedge clk);
        cnt++;
      end while (!ref_pulse);
      check(cnt == r, tag, "reference period", cnt, r);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!fb_pulse && !ref_pulse, "R11", "pulses low in reset",
          int'(fb_pulse) + int'(ref_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!fb_pulse && !ref_pulse && !modulus_hi && !fb_ack && !ref_ack, "R11",
          "outputs low after reset",
          int'(fb_pulse) + int'(ref_pulse) + int'(modulus_hi) + int'(fb_ack) + int'(ref_ack), 0);
    fb_expect(8, 0, 2, "R11");
    ref_expect(6, 2, "R11");

    fb_write(10, 3, 0, 0);   fb_expect(10, 3, 3, "R1");
    fb_write(20, 15, 0, 0);  fb_expect(20, 15, 2, "R2");
    fb_write(20, 15, 0, 1);  fb_expect(20, 7, 2, "R9");
    fb_write(6, 6, 0, 0);    fb_expect(20, 7, 2, "R8");
    fb_write(3, 0, 0, 0);    fb_expect(20, 7, 2, "R8");
    fb_write(50, 2, 1, 0);   fb_expect(20, 2, 2, "R4");
    fb_write(4, 3, 0, 0);    fb_expect(4, 3, 3, "R3");
    fb_write(12, 11, 0, 0);  fb_expect(12, 11, 2, "R3");

    ref_write(9);    ref_expect(9, 2, "R5");
    ref_write(2);    ref_expect(2, 3, "R6");
    ref_write(8191); ref_expect(8191, 2, "R6");
    ref_write(1);    ref_expect(8191, 1, "R8");
    ref_write(5);    ref_expect(5, 2, "R5");

    begin : pd_blk
      int seen = 0;
      int hi_cnt = 0;
      @(negedge clk);
      pd_sel = 2'b00;
      @(negedge clk);
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        seen   += int'(fb_pulse) + int'(ref_pulse);
        hi_cnt += int'(modulus_hi);
      end
      check(seen == 0, "R7", "pulses while powered down", seen, 0);
      check(hi_cnt > 0, "R7", "modulus select keeps running", hi_cnt, 1);
      pd_sel = 2'b11;
    end
    fb_expect(12, 11, 1, "R7");
    ref_expect(5, 1, "R7");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule